// File: doc/BRIEF.md
# Store Drain Buffer with High-Water Arbitration

The block holds retired stores, along with the other ordering operations that must pass through the same queue: barriers, atomic swap, test-and-set, compare-and-swap and flushes. It drains them one at a time to a second-level cache port. Load misses also need that port. While the buffer is lightly used, a load miss takes the port ahead of a store. Once occupancy reaches the high-water mark, stores take it instead, so the buffer never becomes the bottleneck. When all entries are in use, the block refuses new operations.

The block also screens loads that hit in the first-level cache. If the load's address equals a buffered store address, the block raises a fixed-length stall. While any barrier sits in the queue, it asserts a block signal that holds back later loads.

Top module: `store_drain_buf`

## Requirements
- R1: After reset, occupancy is 0, `op_ready_o` is 1, and `drain_valid_o`, `ld_grant_o`, `ld_stall_o` and `ld_block_o` are all 0.
- R2: An accepted operation takes exactly one entry, whatever its kind. The kind encoding is 0 store, 1 barrier, 2 atomic (swap, test-and-set, compare-and-swap) and 3 flush. Occupancy rises by one in the cycle after the operation is accepted.
- R3: While occupancy equals DEPTH (8), `op_ready_o` is 0. An operation offered in that state is dropped and never drains.
- R4: Entries drain in arrival order, one per granted cycle. `drain_addr_o` and `drain_kind_o` carry the oldest entry while `drain_valid_o` is 1.
- R5: With `l2_ready_i` high and occupancy below HWM (5), a pending `ld_miss_req_i` wins the port (`ld_grant_o`=1, `drain_valid_o`=0). With no load request, a non-empty buffer drains.
- R6: With `l2_ready_i` high and occupancy at HWM or above, the store drain wins (`drain_valid_o`=1, `ld_grant_o`=0).
- R7: While `l2_ready_i` is low, both grants stay 0 and nothing drains.
- R8: A first-level hit load (`ld_hit_valid_i`) whose address equals the address of a buffered entry of kind store raises `ld_stall_o` for exactly 7 cycles, starting in the next cycle. Entries of other kinds at the same address do not trigger it.
- R9: `ld_block_o` is 1 exactly while a barrier entry is held. It drops in the cycle after that barrier drains.
- R10: A matching hit load that arrives while `ld_stall_o` is already high neither restarts nor extends the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation offered to the buffer |
| op_kind_i | input | 2 | Operation kind: 0 store, 1 barrier, 2 atomic, 3 flush |
| op_addr_i | input | AW | Operation address |
| op_ready_o | output | 1 | Buffer can accept an operation |
| l2_ready_i | input | 1 | Shared cache port free this cycle |
| ld_miss_req_i | input | 1 | Load miss requests the port |
| ld_grant_o | output | 1 | Port granted to the load miss |
| drain_valid_o | output | 1 | Port granted to the oldest entry, which leaves the buffer |
| drain_kind_o | output | 2 | Kind of the draining entry |
| drain_addr_o | output | AW | Address of the draining entry |
| ld_hit_valid_i | input | 1 | A first-level hit load is presented |
| ld_addr_i | input | AW | Address of that load |
| ld_stall_o | output | 1 | Extra stall for a load that matches a buffered store |
| ld_block_o | output | 1 | A barrier is held; later loads must wait |
| occupancy_o | output | $clog2(DEPTH+1) | Number of held entries |

## Verification
The first pattern fills the buffer with the cache port busy and then offers one more operation. This separates correct full-refusal from overwriting the oldest entry. The second pattern drains with a load miss held high, which shows the exact occupancy at which priority hands back from stores to loads: the store wins at 5 and the load wins at 4. Hit loads are aimed at a store address, at a flush that shares an address, and again during an active stall. These cases separate kind-aware matching from plain address matching and a fixed window from a restartable one. A long random mix of kinds, port availability and load traffic is then compared cycle by cycle with a queue-based model.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  typedef enum logic [1:0] {
    OP_STORE   = 2'd0,
    OP_BARRIER = 2'd1,
    OP_ATOMIC  = 2'd2,
    OP_FLUSH   = 2'd3
  } op_kind_e;
endpackage

// File: rtl/sdb_queue.sv
module sdb_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_i,
  input  logic [1:0]          push_kind_i,
  input  logic [AW-1:0]       push_addr_i,
  input  logic                pop_i,
  output logic [CW-1:0]       count_o,
  output logic [1:0]          head_kind_o,
  output logic [AW-1:0]       head_addr_o,
  output logic [DEPTH-1:0]    slot_live_o,
  output logic [2*DEPTH-1:0]  slot_kind_o,
  output logic [AW*DEPTH-1:0] slot_addr_o
);
  logic [1:0]    kind_q [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= '0;
        addr_q[i] <= '0;
      end
    end else begin
      if (push_i) begin
        kind_q[tail_q] <= push_kind_i;
        addr_q[tail_q] <= push_addr_i;
        tail_q         <= bump(tail_q);
      end
      if (pop_i) head_q <= bump(head_q);
      count_q <= count_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign count_o     = count_q;
  assign head_kind_o = kind_q[head_q];
  assign head_addr_o = addr_q[head_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    int off;
    always_comb begin
      off = (g >= int'(head_q)) ? g - int'(head_q) : g + DEPTH - int'(head_q);
      slot_live_o[g] = off < int'(count_q);
    end
    assign slot_kind_o[2*g +: 2]   = kind_q[g];
    assign slot_addr_o[AW*g +: AW] = addr_q[g];
  end
endmodule

// File: rtl/sdb_arb.sv
module sdb_arb #(
  parameter int DEPTH = 8,
  parameter int HWM   = 5,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count_i,
  input  logic          l2_ready_i,
  input  logic          ld_req_i,
  output logic          drain_go_o,
  output logic          ld_go_o
);
  logic nonempty, high;
  assign nonempty = count_i != '0;
  assign high     = count_i >= CW'(HWM);

  always_comb begin
    drain_go_o = 1'b0;
    ld_go_o    = 1'b0;
    if (l2_ready_i) begin
      if (nonempty && (high || !ld_req_i)) drain_go_o = 1'b1;
      else if (ld_req_i)                   ld_go_o    = 1'b1;
    end
  end
endmodule

// File: rtl/sdb_hazard.sv
module sdb_hazard #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int STALL = 7,
  localparam int SW   = $clog2(STALL + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DEPTH-1:0]    slot_live_i,
  input  logic [2*DEPTH-1:0]  slot_kind_i,
  input  logic [AW*DEPTH-1:0] slot_addr_i,
  input  logic                ld_hit_valid_i,
  input  logic [AW-1:0]       ld_addr_i,
  output logic                stall_o,
  output logic                block_o
);
  import sdb_pkg::*;
  logic [DEPTH-1:0] hit_v, bar_v;
  logic [SW-1:0]    left_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_v[g] = slot_live_i[g] && (slot_kind_i[2*g +: 2] == OP_STORE)
                      && (slot_addr_i[AW*g +: AW] == ld_addr_i);
    assign bar_v[g] = slot_live_i[g] && (slot_kind_i[2*g +: 2] == OP_BARRIER);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        left_q <= '0;
    else if (left_q != '0)              left_q <= left_q - SW'(1);
    else if (ld_hit_valid_i && |hit_v)  left_q <= SW'(STALL);
  end

  assign stall_o = left_q != '0;
  assign block_o = |bar_v;
endmodule

// File: rtl/store_drain_buf.sv
module store_drain_buf #(
  parameter int DEPTH = 8,
  parameter int HWM   = 5,
  parameter int AW    = 16,
  parameter int STALL = 7,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [1:0]    op_kind_i,
  input  logic [AW-1:0] op_addr_i,
  output logic          op_ready_o,
  input  logic          l2_ready_i,
  input  logic          ld_miss_req_i,
  output logic          ld_grant_o,
  output logic          drain_valid_o,
  output logic [1:0]    drain_kind_o,
  output logic [AW-1:0] drain_addr_o,
  input  logic          ld_hit_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  output logic          ld_stall_o,
  output logic          ld_block_o,
  output logic [CW-1:0] occupancy_o
);
  logic                push, pop;
  logic [CW-1:0]       count;
  logic [DEPTH-1:0]    live;
  logic [2*DEPTH-1:0]  kinds;
  logic [AW*DEPTH-1:0] addrs;

  assign op_ready_o = count != CW'(DEPTH);
  assign push       = op_valid_i && op_ready_o;

  sdb_queue #(.DEPTH(DEPTH), .AW(AW)) u_queue (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push), .push_kind_i(op_kind_i), .push_addr_i(op_addr_i),
    .pop_i(pop), .count_o(count),
    .head_kind_o(drain_kind_o), .head_addr_o(drain_addr_o),
    .slot_live_o(live), .slot_kind_o(kinds), .slot_addr_o(addrs)
  );

  sdb_arb #(.DEPTH(DEPTH), .HWM(HWM)) u_arb (
    .count_i(count), .l2_ready_i(l2_ready_i), .ld_req_i(ld_miss_req_i),
    .drain_go_o(pop), .ld_go_o(ld_grant_o)
  );

  sdb_hazard #(.DEPTH(DEPTH), .AW(AW), .STALL(STALL)) u_hazard (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .slot_live_i(live), .slot_kind_i(kinds), .slot_addr_i(addrs),
    .ld_hit_valid_i(ld_hit_valid_i), .ld_addr_i(ld_addr_i),
    .stall_o(ld_stall_o), .block_o(ld_block_o)
  );

  assign drain_valid_o = pop;
  assign occupancy_o   = count;
endmodule

// File: rtl/store_drain_buf_chk.sv
module store_drain_buf_chk #(
  parameter int DEPTH = 8,
  parameter int HWM   = 5,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_valid_i,
  input logic          op_ready_o,
  input logic          l2_ready_i,
  input logic          ld_miss_req_i,
  input logic          ld_grant_o,
  input logic          drain_valid_o,
  input logic [CW-1:0] occupancy_o
);
  p_full_refuse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occupancy_o == CW'(DEPTH) |-> !op_ready_o);

  p_store_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_ready_i && occupancy_o >= CW'(HWM) |-> drain_valid_o && !ld_grant_o);

  p_load_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_ready_i && ld_miss_req_i && occupancy_o < CW'(HWM) |-> ld_grant_o && !drain_valid_o);

  p_port_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l2_ready_i |-> !drain_valid_o && !ld_grant_o);

  p_drain_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_valid_o && !(op_valid_i && op_ready_o) |=> occupancy_o == $past(occupancy_o) - CW'(1));

  p_accept_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drain_valid_o && op_valid_i && op_ready_o |=> occupancy_o == $past(occupancy_o) + CW'(1));
endmodule

bind store_drain_buf store_drain_buf_chk #(.DEPTH(DEPTH), .HWM(HWM)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_ready_o(op_ready_o),
  .l2_ready_i(l2_ready_i), .ld_miss_req_i(ld_miss_req_i), .ld_grant_o(ld_grant_o),
  .drain_valid_o(drain_valid_o), .occupancy_o(occupancy_o)
);

// File: tb/store_drain_buf_test.sv
module store_drain_buf_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_kind = '0;
  logic [AW-1:0] op_addr = '0;
  logic          l2_ready = 1'b0;
  logic          ld_req = 1'b0;
  logic          ld_hit = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic          op_ready, ld_grant, drain_valid, ld_stall, ld_block;
  logic [1:0]    drain_kind;
  logic [AW-1:0] drain_addr;
  logic [3:0]    occ;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [AW+1:0] q[$];
  int stall_left = 0;

  always #5 clk = ~clk;

  store_drain_buf uut (
    .clk_i(clk), .rst_ni(rst_n),
    .op_valid_i(op_valid), .op_kind_i(op_kind), .op_addr_i(op_addr), .op_ready_o(op_ready),
    .l2_ready_i(l2_ready), .ld_miss_req_i(ld_req), .ld_grant_o(ld_grant),
    .drain_valid_o(drain_valid), .drain_kind_o(drain_kind), .drain_addr_o(drain_addr),
    .ld_hit_valid_i(ld_hit), .ld_addr_i(ld_addr),
    .ld_stall_o(ld_stall), .ld_block_o(ld_block), .occupancy_o(occ)
  );

  task automatic chk(input string req, input string name, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, name, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic [AW-1:0] a,
                      input logic rdy, input logic lreq, input logic hit,
                      input logic [AW-1:0] la);
    int cnt;
    bit e_drain, e_ldg, e_match, e_block;
    @(negedge clk);
    op_valid = v; op_kind = k; op_addr = a;
    l2_ready = rdy; ld_req = lreq; ld_hit = hit; ld_addr = la;
    #1;
    cnt = q.size();
    e_drain = rdy && cnt > 0 && (cnt >= 5 || !lreq);
    e_ldg   = rdy && lreq && !e_drain;
    e_match = 0; e_block = 0;
    foreach (q[i]) begin
      if (q[i][AW+1:AW] == 2'd0 && q[i][AW-1:0] == la) e_match = 1;
      if (q[i][AW+1:AW] == 2'd1) e_block = 1;
    end
    chk("R2", "occupancy", int'(occ), cnt);
    chk("R3", "op_ready", int'(op_ready), int'(cnt < 8));
    chk(cnt >= 5 ? "R6" : "R5", "drain_valid", int'(drain_valid), int'(e_drain));
    chk(rdy ? "R5" : "R7", "ld_grant", int'(ld_grant), int'(e_ldg));
    if (e_drain && cnt > 0) begin
      chk("R4", "drain_addr", int'(drain_addr), int'(q[0][AW-1:0]));
      chk("R4", "drain_kind", int'(drain_kind), int'(q[0][AW+1:AW]));
    end
    chk("R8", "ld_stall", int'(ld_stall), int'(stall_left != 0));
    chk("R9", "ld_block", int'(ld_block), int'(e_block));
    // model update at the coming edge; R10: no restart while active
    if (stall_left != 0) stall_left--;
    else if (hit && e_match) stall_left = 7;
    if (e_drain) void'(q.pop_front());
    if (v && cnt < 8) q.push_back({k, a});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #23 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    chk("R1", "occ", int'(occ), 0);
    chk("R1", "ready", int'(op_ready), 1);
    chk("R1", "outs", int'({drain_valid, ld_grant, ld_stall, ld_block}), 0);

    // R2 R3: fill with port busy, mixed kinds
    for (int i = 0; i < 8; i++) begin
      logic [1:0] kk;
      kk = (i == 3) ? 2'd1 : (i == 5) ? 2'd2 : (i == 6) ? 2'd3 : 2'd0;
      step(1, kk, AW'(16'h100 + i), 0, 1, 0, 0);
    end
    step(1, 0, 16'h1ff, 0, 1, 0, 0);            // R3 offered while full
    step(0, 0, 0, 0, 0, 1, 16'h100);            // R8 matching store
    step(0, 0, 0, 0, 0, 1, 16'h101);            // R10 match during stall
    idle(3);
    step(0, 0, 0, 0, 0, 1, 16'h102);            // R10 still no extension
    idle(4);
    step(0, 0, 0, 0, 0, 1, 16'h106);            // R8 flush address: no stall
    idle(2);

    // R5 R6 R4 R9: drain with load miss pending
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1, 0, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, 0);
    idle(2);

    // random mix, R2..R10
    for (int i = 0; i < 4000; i++) begin
      step(1'($urandom % 3 != 0), 2'($urandom), AW'(16'h200 + ($urandom % 6)),
           1'($urandom % 3 == 0), 1'($urandom % 2), 1'($urandom % 4 == 0),
           AW'(16'h200 + ($urandom % 6)));
    end
    idle(20);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule